// File: doc/BRIEF.md
# NAND Operation Launch and Completion Unit

This block sits between a CPU register bus and a NAND flash pin engine. Software loads a command value, an address value and a buffer selection. It then starts one flash operation by writing a single one-hot launch bit into the second configuration register. The launch bits select command cycle, address cycle, data-in transfer, data-out transfer, identifier read or status read. The pin-level timing and the page RAM are not part of this block. A programmable busy counter stands in for them, so every operation completes a known number of cycles after launch.

On completion the unit sets a sticky completion flag. The flag raises the interrupt line unless the mask bit is set, and it stays readable either way. Two operations also capture a result into a three-halfword result buffer. A status read stores the device status word in halfword 0 and leaves halfwords 1 and 2 alone. An identifier read stores six ID bytes. When the flash bus is 16 bits wide, those bytes are taken from every other raw byte lane. Software must wait for each operation to finish before it launches the next. A launch attempted while busy, or with more than one bit set, is refused and flagged.

Large pages move as several 512-byte buffer transfers. Software selects each one through the buffer index, and the chip select sits in bits [5:4] of the same register. Both values are latched at launch.

Top module: `nfc_launch_ctrl`

## Requirements
- R1: After reset, offset 3 reads 0x0010 (mask set, narrow bus), offset 4 reads 0x0000, offset 5 reads 4, and `irq_o`, `busy_o` and `op_o` are all zero.
- R2: A write to offset 4 while idle, with exactly one of bits [5:0] set, starts that operation. From the next cycle `busy_o` is 1 and `op_o` equals those bits. The bits are: 0 command, 1 address, 2 data in, 3 data out, 4 ID read, 5 status read.
- R3: The operation stays busy for L = max(latency, 1) cycles, where latency is the value at offset 5. At the L-th clock edge after the launch edge, `busy_o` falls and completion flag bit 15 of offset 4 becomes 1.
- R4: The completion flag is sticky. A write to offset 4 with bit 15 = 0 clears it, and bit 15 = 1 leaves it unchanged. A completion in the same cycle as a clearing write leaves the flag set.
- R5: `irq_o` equals the completion flag when mask bit 4 of offset 3 is 0, and is 0 when the mask is 1. Bit 15 of offset 4 stays readable while masked.
- R6: A launch write with two or more of bits [5:0] set, or any nonzero launch write while busy, starts nothing and leaves the running operation unchanged. Such a write sets error bit 14 of offset 4. Any other write to offset 4 with bit 14 = 0 clears the error bit.
- R7: When a status read completes, `dev_status_i` is stored in result halfword 0 (offset 6). Offsets 7 and 8 keep their values.
- R8: When an ID read completes, result byte k is stored at offset 6 + k/2, in the low byte for even k. The byte is raw byte k of `dev_id_i` when bit 0 of offset 3 is 0, and raw byte 2k when that bit is 1 (16-bit bus).
- R9: Offset 2 holds the chip select in bits [5:4] and the buffer index in bits [1:0], and its other bits read as 0. Both fields are copied to `cur_cs_o` and `cur_buf_o` at launch and stay constant during the operation, even if offset 2 is rewritten.
- R10: Offsets 0 and 1 read back the command and address values last written, and drive `cmd_o` and `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| dev_status_i | input | 16 | Status word returned by the flash |
| dev_id_i | input | 88 | Raw identifier bytes, byte k at bits [8k+7:8k] |
| cmd_o | output | 16 | Command value for the pin engine |
| addr_o | output | 16 | Address value for the pin engine |
| op_o | output | 6 | One-hot active operation, zero when idle |
| busy_o | output | 1 | Operation in progress |
| cur_cs_o | output | 2 | Chip select latched at launch |
| cur_buf_o | output | 2 | Buffer index latched at launch |
| irq_o | output | 1 | Completion interrupt |

## Verification
A wrong busy count appears as `busy_o` dropping one or more cycles early or late, so the latency sweep catches it at the first completion. A corrupted launch decode shows at once as a wrong `op_o`, or as a missing or spurious error bit, on the cycle after the launch write. A stale mask or completion flag shows up on `irq_o` right after the register write that should have changed it. Mistakes in result capture only appear when the buffer is read after the operation ends. The bench therefore reads all three halfwords after each ID and status operation.

// File: rtl/nfc_launch_pkg.sv
// Shared offsets and bit positions for the NAND launch unit.
// Assumes a 4-bit register offset and 16-bit register data.
package nfc_launch_pkg;
    localparam int NUM_OPS = 6;
    localparam int CS_W    = 2;

    // Register offsets
    localparam logic [3:0] RA_CMD  = 4'd0;
    localparam logic [3:0] RA_ADDR = 4'd1;
    localparam logic [3:0] RA_BUF  = 4'd2;
    localparam logic [3:0] RA_CFGA = 4'd3;
    localparam logic [3:0] RA_CFGB = 4'd4;
    localparam logic [3:0] RA_LAT  = 4'd5;
    localparam logic [3:0] RA_RES0 = 4'd6;

    // Launch bit positions (one-hot)
    localparam int OP_CMD  = 0;
    localparam int OP_ADDR = 1;
    localparam int OP_DIN  = 2;
    localparam int OP_DOUT = 3;
    localparam int OP_ID   = 4;
    localparam int OP_STAT = 5;

    // Field positions
    localparam int CFGA_WIDE_BIT = 0;
    localparam int CFGA_MASK_BIT = 4;
    localparam int CFGB_ERR_BIT  = 14;
    localparam int CFGB_DONE_BIT = 15;
    localparam int BUF_CS_LSB    = 4;
endpackage

// File: rtl/nfc_regs.sv
// Software-written configuration registers: command, address, buffer
// selection, bus width / interrupt mask, and operation latency.
// Assumes BUF_IDX_W <= 4 and LAT_W <= DATA_W.
module nfc_regs
    import nfc_launch_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int LAT_W     = 8,
    parameter int BUF_IDX_W = 2,
    parameter int DEF_LAT   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [3:0]           addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    cmd_q,
    output logic [DATA_W-1:0]    addr_q,
    output logic [BUF_IDX_W-1:0] buf_idx_q,
    output logic [CS_W-1:0]      cs_q,
    output logic                 wide_q,
    output logic                 mask_q,
    output logic [LAT_W-1:0]     lat_q
);
    // Register updates on software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            addr_q    <= '0;
            buf_idx_q <= '0;
            cs_q      <= '0;
            wide_q    <= 1'b0;
            mask_q    <= 1'b1;
            lat_q     <= LAT_W'(DEF_LAT);
        end else if (we) begin
            case (addr)
                RA_CMD:  cmd_q  <= wdata;
                RA_ADDR: addr_q <= wdata;
                RA_BUF: begin
                    buf_idx_q <= wdata[BUF_IDX_W-1:0];
                    cs_q      <= wdata[BUF_CS_LSB +: CS_W];
                end
                RA_CFGA: begin
                    wide_q <= wdata[CFGA_WIDE_BIT];
                    mask_q <= wdata[CFGA_MASK_BIT];
                end
                RA_LAT:  lat_q  <= wdata[LAT_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nfc_launch.sv
// Launch validation and busy counter. Accepts a single one-hot launch
// while idle, runs it for max(lat,1) cycles, then sets a sticky
// completion flag. Refused launches set a sticky error flag.
// Assumes the launch strobe comes from a register write to the
// second configuration register.
module nfc_launch
    import nfc_launch_pkg::*;
#(
    parameter int LAT_W     = 8,
    parameter int BUF_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfgb_we,
    input  logic [NUM_OPS-1:0]   req,
    input  logic                 keep_done,
    input  logic                 keep_err,
    input  logic [LAT_W-1:0]     lat,
    input  logic [BUF_IDX_W-1:0] buf_idx,
    input  logic [CS_W-1:0]      cs,
    output logic [NUM_OPS-1:0]   op_q,
    output logic                 busy,
    output logic                 fin,
    output logic                 done_q,
    output logic                 err_q,
    output logic [BUF_IDX_W-1:0] cur_buf_q,
    output logic [CS_W-1:0]      cur_cs_q
);
    logic [LAT_W-1:0] cnt_q;
    logic [LAT_W-1:0] lat_eff;
    logic             single;
    logic             accept;
    logic             reject;

    // Decode launch request and effective latency
    always_comb begin
        single  = (req != '0) && ((req & (req - NUM_OPS'(1))) == '0);
        accept  = cfgb_we && single && !busy;
        reject  = cfgb_we && (req != '0) && !accept;
        lat_eff = (lat == '0) ? LAT_W'(1) : lat;
    end

    assign busy = (op_q != '0);
    assign fin  = busy && (cnt_q == LAT_W'(1));

    // Active operation, counter and latched selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= '0;
            cnt_q     <= '0;
            cur_buf_q <= '0;
            cur_cs_q  <= '0;
        end else if (accept) begin
            op_q      <= req;
            cnt_q     <= lat_eff;
            cur_buf_q <= buf_idx;
            cur_cs_q  <= cs;
        end else if (fin) begin
            op_q  <= '0;
            cnt_q <= '0;
        end else if (busy) begin
            cnt_q <= cnt_q - LAT_W'(1);
        end
    end

    // Sticky completion flag: completion wins over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n)                      done_q <= 1'b0;
        else if (fin)                    done_q <= 1'b1;
        else if (cfgb_we && !keep_done)  done_q <= 1'b0;
    end

    // Sticky error flag for refused launches
    always_ff @(posedge clk) begin
        if (!rst_n)                     err_q <= 1'b0;
        else if (reject)                err_q <= 1'b1;
        else if (cfgb_we && !keep_err)  err_q <= 1'b0;
    end
endmodule

// File: rtl/nfc_result.sv
// Result buffer standing in for the first halfwords of main buffer 0.
// A status read fills halfword 0; an ID read fills all bytes, taking
// every other raw lane on a 16-bit bus. Assumes ID_BYTES >= 2.
module nfc_result #(
    parameter int ID_BYTES = 6,
    parameter int RAW_B    = 2 * ID_BYTES - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fin_id,
    input  logic                  fin_stat,
    input  logic                  wide,
    input  logic [15:0]           status,
    input  logic [8*RAW_B-1:0]    raw,
    output logic [8*ID_BYTES-1:0] res
);
    for (genvar k = 0; k < ID_BYTES; k++) begin : g_byte
        logic [7:0] pick;
        // Lane selection by bus width
        always_comb pick = wide ? raw[8*(2*k) +: 8] : raw[8*k +: 8];

        if (k < 2) begin : g_stat
            // Byte shared by status and ID results
            always_ff @(posedge clk) begin
                if (!rst_n)        res[8*k +: 8] <= '0;
                else if (fin_id)   res[8*k +: 8] <= pick;
                else if (fin_stat) res[8*k +: 8] <= status[8*k +: 8];
            end
        end else begin : g_id
            // Byte written only by ID results
            always_ff @(posedge clk) begin
                if (!rst_n)      res[8*k +: 8] <= '0;
                else if (fin_id) res[8*k +: 8] <= pick;
            end
        end
    end
endmodule

// File: rtl/nfc_launch_ctrl.sv
// Top of the NAND launch unit: register file, launch/busy engine,
// result buffer and read-back multiplexer. Assumes 16-bit data.
module nfc_launch_ctrl
    import nfc_launch_pkg::*;
#(
    parameter int LAT_W     = 8,
    parameter int BUF_IDX_W = 2,
    parameter int DEF_LAT   = 4,
    parameter int ID_BYTES  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [3:0]                 reg_addr,
    input  logic [15:0]                reg_wdata,
    output logic [15:0]                reg_rdata,
    input  logic [15:0]                dev_status_i,
    input  logic [8*(2*ID_BYTES-1)-1:0] dev_id_i,
    output logic [15:0]                cmd_o,
    output logic [15:0]                addr_o,
    output logic [NUM_OPS-1:0]         op_o,
    output logic                       busy_o,
    output logic [CS_W-1:0]            cur_cs_o,
    output logic [BUF_IDX_W-1:0]       cur_buf_o,
    output logic                       irq_o
);
    localparam int DATA_W = 16;
    localparam int RES_HW = (ID_BYTES + 1) / 2;

    logic [BUF_IDX_W-1:0]   buf_idx_q;
    logic [CS_W-1:0]        cs_q;
    logic                   wide_q;
    logic                   mask_q;
    logic [LAT_W-1:0]       lat_q;
    logic                   fin;
    logic                   done_q;
    logic                   err_q;
    logic                   cfgb_we;
    logic [8*ID_BYTES-1:0]  res;
    logic [16*RES_HW-1:0]   res_pad;

    assign cfgb_we = reg_we && (reg_addr == RA_CFGB);

    nfc_regs #(
        .DATA_W(DATA_W), .LAT_W(LAT_W), .BUF_IDX_W(BUF_IDX_W), .DEF_LAT(DEF_LAT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cmd_q(cmd_o), .addr_q(addr_o), .buf_idx_q(buf_idx_q), .cs_q(cs_q),
        .wide_q(wide_q), .mask_q(mask_q), .lat_q(lat_q)
    );

    nfc_launch #(
        .LAT_W(LAT_W), .BUF_IDX_W(BUF_IDX_W)
    ) u_launch (
        .clk(clk), .rst_n(rst_n), .cfgb_we(cfgb_we),
        .req(reg_wdata[NUM_OPS-1:0]),
        .keep_done(reg_wdata[CFGB_DONE_BIT]), .keep_err(reg_wdata[CFGB_ERR_BIT]),
        .lat(lat_q), .buf_idx(buf_idx_q), .cs(cs_q),
        .op_q(op_o), .busy(busy_o), .fin(fin), .done_q(done_q), .err_q(err_q),
        .cur_buf_q(cur_buf_o), .cur_cs_q(cur_cs_o)
    );

    nfc_result #(
        .ID_BYTES(ID_BYTES)
    ) u_result (
        .clk(clk), .rst_n(rst_n),
        .fin_id(fin && op_o[OP_ID]), .fin_stat(fin && op_o[OP_STAT]),
        .wide(wide_q), .status(dev_status_i), .raw(dev_id_i), .res(res)
    );

    assign res_pad = (16*RES_HW)'(res);

    // Interrupt gating by the mask bit
    assign irq_o = done_q && !mask_q;

    // Read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CMD:  reg_rdata = cmd_o;
            RA_ADDR: reg_rdata = addr_o;
            RA_BUF: begin
                reg_rdata[BUF_IDX_W-1:0]        = buf_idx_q;
                reg_rdata[BUF_CS_LSB +: CS_W]   = cs_q;
            end
            RA_CFGA: begin
                reg_rdata[CFGA_WIDE_BIT] = wide_q;
                reg_rdata[CFGA_MASK_BIT] = mask_q;
            end
            RA_CFGB: begin
                reg_rdata[NUM_OPS-1:0]   = op_o;
                reg_rdata[CFGB_ERR_BIT]  = err_q;
                reg_rdata[CFGB_DONE_BIT] = done_q;
            end
            RA_LAT:  reg_rdata = DATA_W'(lat_q);
            default: begin
                for (int h = 0; h < RES_HW; h++)
                    if (reg_addr == 4'(RA_RES0 + h)) reg_rdata = res_pad[16*h +: 16];
            end
        endcase
    end
endmodule

// File: rtl/nfc_launch_ctrl_chk.sv
// Temporal checks for the NAND launch unit, bound to the top module.
module nfc_launch_ctrl_chk
    import nfc_launch_pkg::*;
#(
    parameter int BUF_IDX_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [3:0]           reg_addr,
    input logic [15:0]          reg_wdata,
    input logic [NUM_OPS-1:0]   op_o,
    input logic                 busy_o,
    input logic [CS_W-1:0]      cur_cs_o,
    input logic [BUF_IDX_W-1:0] cur_buf_o,
    input logic                 irq_o,
    input logic                 done_q,
    input logic                 err_q,
    input logic                 mask_q
);
    // R2
    single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_o));

    // R2
    launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(reg_we && reg_addr == RA_CFGB
                                && $countones(reg_wdata[NUM_OPS-1:0]) == 1));

    // R3
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $fell(busy_o));

    // R6
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(reg_we && reg_addr == RA_CFGB));

    // R5
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !irq_o);

    // R9
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(cur_cs_o) && $stable(cur_buf_o) && $stable(op_o)));
endmodule

bind nfc_launch_ctrl nfc_launch_ctrl_chk #(.BUF_IDX_W(BUF_IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .op_o(op_o), .busy_o(busy_o), .cur_cs_o(cur_cs_o),
    .cur_buf_o(cur_buf_o), .irq_o(irq_o), .done_q(done_q), .err_q(err_q),
    .mask_q(mask_q)
);

// File: tb/tb_nfc_launch_ctrl.sv
// Self-checking bench for the NAND launch unit.
module tb_nfc_launch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] dev_status_i = '0;
    logic [87:0] dev_id_i;
    logic [15:0] cmd_o, addr_o;
    logic [5:0]  op_o;
    logic        busy_o, irq_o;
    logic [1:0]  cur_cs_o, cur_buf_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    nfc_launch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_status_i(dev_status_i),
        .dev_id_i(dev_id_i), .cmd_o(cmd_o), .addr_o(addr_o), .op_o(op_o),
        .busy_o(busy_o), .cur_cs_o(cur_cs_o), .cur_buf_o(cur_buf_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy_o && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int cyc;
        for (int i = 0; i < 11; i++) dev_id_i[8*i +: 8] = 8'hA0 + 8'(i);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd3, v); chk("R1 cfga", v, 16'h0010);
        rd(4'd4, v); chk("R1 cfgb", v, 16'h0000);
        rd(4'd5, v); chk("R1 lat", v, 16'd4);
        chk("R1 irq", irq_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 op", op_o, 0);

        // R10 command and address registers
        wr(4'd0, 16'h0070); wr(4'd1, 16'h1234);
        rd(4'd0, v); chk("R10 cmd rd", v, 16'h0070);
        rd(4'd1, v); chk("R10 addr rd", v, 16'h1234);
        chk("R10 cmd_o", cmd_o, 16'h0070);
        chk("R10 addr_o", addr_o, 16'h1234);

        // R9 buffer-address fields
        wr(4'd2, 16'h0032); rd(4'd2, v); chk("R9 buf rd", v, 16'h0032);
        wr(4'd2, 16'hFFFF); rd(4'd2, v); chk("R9 buf mask", v, 16'h0033);
        wr(4'd2, 16'h0021);

        // R3 latency sweep over command/address/data ops
        for (int lat = 0; lat < 7; lat++) begin
            logic [5:0] opb;
            opb = 6'(1 << (lat % 4));
            wr(4'd5, 16'(lat));
            wr(4'd4, {10'd0, opb});
            chk("R2 busy", busy_o, 1);
            chk("R2 op", op_o, opb);
            chk("R9 cs", cur_cs_o, 2);
            chk("R9 buf", cur_buf_o, 1);
            wait_idle(cyc);
            chk("R3 cycles", cyc, (lat == 0) ? 1 : lat);
            rd(4'd4, v); chk("R3 done", v, 16'h8000);
            chk("R5 masked irq", irq_o, 0);
        end

        // R2 / R6 launch-pattern sweep
        wr(4'd5, 16'd1);
        for (int p = 0; p < 64; p++) begin
            bit one;
            one = ($countones(p) == 1);
            wr(4'd4, 16'(p));
            chk(one ? "R2 accept busy" : "R6 refuse busy", busy_o, one);
            if (one) chk("R2 accept op", op_o, p);
            rd(4'd4, v);
            chk(one ? "R2 completes" : "R6 err flag", v,
                one ? 16'h8000 : ((p == 0) ? 16'h0000 : 16'h4000));
        end

        // R6 refusal while busy, R9 hold during op
        wr(4'd5, 16'd10);
        wr(4'd4, 16'h0004);
        wr(4'd2, 16'h0010);
        wr(4'd4, 16'h0002);
        chk("R6 op kept", op_o, 6'h04);
        chk("R9 cs held", cur_cs_o, 2);
        chk("R9 buf held", cur_buf_o, 1);
        wait_idle(cyc);
        chk("R6 timing kept", cyc + 4, 10);
        rd(4'd4, v); chk("R6 done and err", v, 16'hC000);
        wr(4'd4, 16'h8000);
        rd(4'd4, v); chk("R4 keep done clear err", v, 16'h8000);

        // R5 mask gating
        wr(4'd3, 16'h0000); chk("R5 irq unmasked", irq_o, 1);
        wr(4'd3, 16'h0010); chk("R5 irq masked", irq_o, 0);
        rd(4'd4, v); chk("R5 flag readable", v, 16'h8000);
        wr(4'd3, 16'h0000); chk("R5 irq again", irq_o, 1);
        wr(4'd4, 16'h0000); chk("R4 clear irq", irq_o, 0);

        // R4 completion against same-cycle clear
        wr(4'd5, 16'd2);
        wr(4'd4, 16'h0001);
        wr(4'd4, 16'h0000);
        rd(4'd4, v); chk("R4 completion wins", v, 16'h8000);
        chk("R4 irq", irq_o, 1);

        // R8 ID narrow bus
        wr(4'd5, 16'd3);
        wr(4'd4, 16'h0010); wait_idle(cyc);
        rd(4'd6, v); chk("R8 narrow h0", v, 16'hA1A0);
        rd(4'd7, v); chk("R8 narrow h1", v, 16'hA3A2);
        rd(4'd8, v); chk("R8 narrow h2", v, 16'hA5A4);

        // R8 ID wide bus
        wr(4'd3, 16'h0001);
        wr(4'd4, 16'h0010); wait_idle(cyc);
        rd(4'd6, v); chk("R8 wide h0", v, 16'hA2A0);
        rd(4'd7, v); chk("R8 wide h1", v, 16'hA6A4);
        rd(4'd8, v); chk("R8 wide h2", v, 16'hAAA8);

        // R7 status read
        dev_status_i = 16'h5AC3;
        wr(4'd4, 16'h0020); wait_idle(cyc);
        rd(4'd6, v); chk("R7 status h0", v, 16'h5AC3);
        rd(4'd7, v); chk("R7 h1 kept", v, 16'hA6A4);
        rd(4'd8, v); chk("R7 h2 kept", v, 16'hAAA8);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule